// File: doc/BRIEF.md
# Register Bit Field Operation Unit

This unit performs bit-field operations on a single 32-bit register operand. A field is a run of 1 to 32 adjacent bits. Its position is given by a signed offset and its size by a width code. Field bits are counted from the most significant end of the word: field bit 0 is the field's top bit, and later field bits move toward bit 0 of the word. A field that runs past bit 0 continues at bit 31.

One request is accepted per cycle on `start`. One clock edge later the unit presents four things, with `valid` high for that cycle:
- the updated register value;
- a 32-bit result, used by the extract and locate operations;
- a negative flag;
- a zero flag.

All eight operations share one datapath. That datapath rotates the field to the top of the word, masks it, modifies it there, and rotates it back.

Top module: `bitfield_unit`

## Requirements
- R1: `valid` is high in the cycle after a cycle with `start` high, and low otherwise. All outputs are registered and are updated only after a `start` cycle; without `start` they hold. Reset (`rst_n` low, asynchronous) clears every output to 0.
- R2: Only `offset[4:0]` (value o) selects the position. Field bit i lies at word bit 31 − ((o + i) mod 32), so a field wraps from bit 0 to bit 31.
- R3: A `width_code` of 0 selects a 32-bit field. Codes 1 to 31 select that many bits.
- R4: Opcode 1 (extract unsigned) puts the field in the low bits of `result`, with field bit 0 as the highest of them, and clears all bits above.
- R5: Opcode 3 (extract signed) works like opcode 1, except that every bit above the field copies field bit 0.
- R6: Opcode 7 (insert) writes the low width bits of `src` into the field: src bit width−1 goes to field bit 0. Bits outside the field are unchanged. The flags describe the inserted value.
- R7: Opcode 6 sets every field bit, opcode 4 clears every field bit and opcode 2 inverts every field bit. Bits outside the field are unchanged in all three. The flags describe the field before the change.
- R8: Opcode 0 (test) sets the flags from the field and returns `new_reg` equal to `dest`.
- R9: Opcode 5 (find first one) returns, in `result`, the 32-bit `offset` plus the index of the first 1 found when scanning from field bit 0. If the field holds no 1, it returns `offset` plus the width. The addition wraps modulo 2^32.
- R10: `flag_n` equals field bit 0 and `flag_z` is 1 when all field bits are 0. Opcodes 0, 1, 3 and 5 return `new_reg` = `dest`. Every opcode other than 1, 3 and 5 returns `result` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, one operation per cycle |
| opcode | input | 3 | Operation select |
| dest | input | 32 | Register operand holding the field |
| src | input | 32 | Value to insert, taken from its low bits |
| offset | input | 32 | Signed field offset |
| width_code | input | 5 | Field width, 0 meaning 32 |
| valid | output | 1 | Outputs are from the previous request |
| new_reg | output | 32 | Updated register value |
| result | output | 32 | Extracted field or located offset |
| flag_n | output | 1 | Field top bit |
| flag_z | output | 1 | Field is all zero |

## Verification
The bench targets these corner cases:
- **Fields that wrap past bit 0.** A design that forgot the rotation would alter or read bits at the wrong end of the word.
- **Width code 0.** A design that took it literally would handle an empty field and leave `dest` untouched.
- **Find-first-one with a negative offset, and with an empty field near the top of the signed range.** A design that added only the low offset bits, or saturated the sum, would return a different 32-bit result.
- **Signed extract of a field with top bit 1.** Without the fill, the upper bits of `result` would stay clear.
- **Insert.** Taking the flags from the old field instead of from `src` would give the wrong flags.

// File: rtl/bf_pkg.sv
package bf_pkg;

    typedef enum logic [2:0] {
        OP_TEST = 3'd0,
        OP_EXTU = 3'd1,
        OP_CHG  = 3'd2,
        OP_EXTS = 3'd3,
        OP_CLR  = 3'd4,
        OP_FFO  = 3'd5,
        OP_SET  = 3'd6,
        OP_INS  = 3'd7
    } bf_op_e;

    function automatic logic op_writes_field(input bf_op_e op);
        return (op == OP_CHG) || (op == OP_CLR) || (op == OP_SET) || (op == OP_INS);
    endfunction

endpackage

// File: rtl/bf_rot.sv
module bf_rot #(
    parameter int W     = 32,
    parameter bit LEFT  = 1'b1,
    localparam int AW   = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [2*W-1:0] doubled;

    generate
        if (LEFT) begin : g_left
            assign doubled = {din, din} << amt;
            assign dout    = doubled[2*W-1:W];
        end else begin : g_right
            assign doubled = {din, din} >> amt;
            assign dout    = doubled[W-1:0];
        end
    endgenerate
endmodule

// File: rtl/bf_mask_gen.sv
module bf_mask_gen #(
    parameter int W   = 32,
    localparam int CW = $clog2(W) + 1
) (
    input  logic [CW-1:0] fw,
    output logic [W-1:0]  top_mask
);
    always_comb begin
        top_mask = ~({W{1'b1}} >> fw);
    end
endmodule

// File: rtl/bf_lead_zero.sv
module bf_lead_zero #(
    parameter int W   = 32,
    localparam int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  din,
    output logic [CW-1:0] count,
    output logic          found
);
    always_comb begin
        count = CW'(W);
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (din[i]) begin
                count = CW'(W - 1 - i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
    import bf_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int POS_W = $clog2(DATA_W),
    localparam int CNT_W = POS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        opcode,
    input  logic [DATA_W-1:0] dest,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] offset,
    input  logic [POS_W-1:0]  width_code,
    output logic              valid,
    output logic [DATA_W-1:0] new_reg,
    output logic [DATA_W-1:0] result,
    output logic              flag_n,
    output logic              flag_z
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] reg_v;
        logic [DATA_W-1:0] res;
        logic              n;
        logic              z;
    } bf_state_t;

    bf_state_t st_d, st_q;

    bf_op_e            op;
    logic [POS_W-1:0]  start_pos;
    logic [CNT_W-1:0]  fw;
    logic [CNT_W-1:0]  ralign;
    logic [DATA_W-1:0] dest_rot;
    logic [DATA_W-1:0] top_mask;
    logic [DATA_W-1:0] field_rot;
    logic [DATA_W-1:0] ins_aligned;
    logic [DATA_W-1:0] mod_rot;
    logic [DATA_W-1:0] mod_reg;
    logic [DATA_W-1:0] ext_u;
    logic [DATA_W-1:0] ext_s;
    logic [CNT_W-1:0]  lz_cnt;
    logic              lz_found;

    assign op        = bf_op_e'(opcode);
    assign start_pos = offset[POS_W-1:0];
    assign fw        = (width_code == '0) ? CNT_W'(DATA_W) : {1'b0, width_code};
    assign ralign    = CNT_W'(DATA_W) - fw;

    // Field top bit moves to the word's top bit.
    bf_rot #(.W(DATA_W), .LEFT(1'b1)) u_rot_in (
        .din  (dest),
        .amt  (start_pos),
        .dout (dest_rot)
    );

    bf_mask_gen #(.W(DATA_W)) u_mask (
        .fw       (fw),
        .top_mask (top_mask)
    );

    assign field_rot   = dest_rot & top_mask;
    assign ins_aligned = src << ralign;

    bf_lead_zero #(.W(DATA_W)) u_lz (
        .din   (field_rot),
        .count (lz_cnt),
        .found (lz_found)
    );

    always_comb begin
        unique case (op)
            OP_SET:  mod_rot = dest_rot | top_mask;
            OP_CLR:  mod_rot = dest_rot & ~top_mask;
            OP_CHG:  mod_rot = dest_rot ^ top_mask;
            OP_INS:  mod_rot = (dest_rot & ~top_mask) | (ins_aligned & top_mask);
            default: mod_rot = dest_rot;
        endcase
    end

    // Rotate the modified word back into place.
    bf_rot #(.W(DATA_W), .LEFT(1'b0)) u_rot_out (
        .din  (mod_rot),
        .amt  (start_pos),
        .dout (mod_reg)
    );

    assign ext_u = dest_rot >> ralign;
    assign ext_s = DATA_W'($signed(dest_rot) >>> ralign);

    always_comb begin
        st_d       = st_q;
        st_d.valid = start;
        if (start) begin
            st_d.reg_v = op_writes_field(op) ? mod_reg : dest;
            st_d.n     = dest_rot[DATA_W-1];
            st_d.z     = (field_rot == '0);
            st_d.res   = '0;
            unique case (op)
                OP_EXTU: st_d.res = ext_u;
                OP_EXTS: st_d.res = ext_s;
                OP_FFO:  st_d.res = offset + DATA_W'(lz_found ? lz_cnt : fw);
                OP_INS: begin
                    st_d.n = ins_aligned[DATA_W-1];
                    st_d.z = (ins_aligned == '0);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid   = st_q.valid;
    assign new_reg = st_q.reg_v;
    assign result  = st_q.res;
    assign flag_n  = st_q.n;
    assign flag_z  = st_q.z;
endmodule

// File: rtl/bf_unit_chk.sv
module bf_unit_chk
    import bf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [2:0]        opcode,
    input logic [DATA_W-1:0] dest,
    input logic              valid,
    input logic [DATA_W-1:0] new_reg,
    input logic [DATA_W-1:0] result,
    input logic              flag_n,
    input logic              flag_z
);
    p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);
    p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !valid);
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(new_reg) && $stable(result) && $stable(flag_n) && $stable(flag_z)));
    p_test_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode == OP_TEST) |=> (new_reg == $past(dest) && result == '0));
    p_extu_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode == OP_EXTU) |=> (new_reg == $past(dest)));
    p_clear_no_new_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode == OP_CLR) |=> ((new_reg & ~$past(dest)) == '0));
    p_set_no_lost_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode == OP_SET) |=> ((~new_reg & $past(dest)) == '0));
    p_chg_alters_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode == OP_CHG) |=> (new_reg != $past(dest)));
    p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !(flag_n && flag_z));
endmodule

bind bitfield_unit bf_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .opcode  (opcode),
    .dest    (dest),
    .valid   (valid),
    .new_reg (new_reg),
    .result  (result),
    .flag_n  (flag_n),
    .flag_z  (flag_z)
);

// File: tb/bitfield_unit_test.sv
module bitfield_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  opcode = '0;
    logic [31:0] dest = '0;
    logic [31:0] src = '0;
    logic [31:0] offset = '0;
    logic [4:0]  width_code = '0;
    logic        valid;
    logic [31:0] new_reg;
    logic [31:0] result;
    logic        flag_n;
    logic        flag_z;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitfield_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .dest(dest), .src(src), .offset(offset), .width_code(width_code),
        .valid(valid), .new_reg(new_reg), .result(result),
        .flag_n(flag_n), .flag_z(flag_z)
    );

    // Bit-by-bit reference built from the requirements.
    function automatic void ref_model(
        input  logic [2:0]  op,
        input  logic [31:0] d,
        input  logic [31:0] s,
        input  logic [31:0] off,
        input  logic [4:0]  wc,
        output logic [31:0] nr,
        output logic [31:0] res,
        output logic        n,
        output logic        z
    );
        int w;
        int o;
        int k;
        logic [31:0] fld;
        w   = (wc == 0) ? 32 : int'(wc);
        o   = int'(off[4:0]);
        fld = '0;
        n   = 1'b0;
        z   = 1'b1;
        nr  = d;
        res = '0;
        k   = w;
        for (int i = 0; i < w; i++) begin
            int p;
            p = 31 - ((o + i) % 32);
            fld = {fld[30:0], d[p]};
            if (i == 0) n = d[p];
            if (d[p]) z = 1'b0;
            if (d[p] && k == w) k = i;
            case (op)
                3'd6: nr[p] = 1'b1;
                3'd4: nr[p] = 1'b0;
                3'd2: nr[p] = ~d[p];
                3'd7: nr[p] = s[w-1-i];
                default: ;
            endcase
        end
        case (op)
            3'd1: res = fld;
            3'd3: begin
                res = fld;
                for (int j = w; j < 32; j++) res[j] = n;
            end
            3'd5: res = off + 32'(k);
            3'd7: begin
                n = s[w-1];
                z = 1'b1;
                for (int j = 0; j < w; j++) if (s[j]) z = 1'b0;
            end
            default: ;
        endcase
    endfunction

    task automatic fail_line(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        errors++;
        $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
    endtask

    task automatic run_op(input string req, input logic [2:0] op, input logic [31:0] d,
                          input logic [31:0] s, input logic [31:0] off, input logic [4:0] wc);
        logic [31:0] e_nr, e_res;
        logic e_n, e_z;
        ref_model(op, d, s, off, wc, e_nr, e_res, e_n, e_z);
        @(negedge clk);
        opcode = op; dest = d; src = s; offset = off; width_code = wc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        checks++;
        if (valid !== 1'b1 || new_reg !== e_nr || result !== e_res ||
            flag_n !== e_n || flag_z !== e_z) begin
            if (valid !== 1'b1) fail_line("R1", "valid", 32'(valid), 32'd1);
            if (new_reg !== e_nr) fail_line(req, "new_reg", new_reg, e_nr);
            if (result !== e_res) fail_line(req, "result", result, e_res);
            if (flag_n !== e_n || flag_z !== e_z)
                fail_line("R10", "flags nz", {30'd0, flag_n, flag_z}, {30'd0, e_n, e_z});
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (valid !== 1'b0 || new_reg !== '0 || result !== '0 || flag_n !== 1'b0 || flag_z !== 1'b0)
            fail_line("R1", "reset state", new_reg | result | 32'(valid), 32'd0);

        // R2: wrap from bit 0 to bit 31
        run_op("R2", 3'd0, 32'h8000_0001, '0, 32'd31, 5'd2);
        run_op("R2", 3'd1, 32'hA000_0005, '0, 32'd30, 5'd5);
        run_op("R2", 3'd4, 32'hFFFF_FFFF, '0, 32'd29, 5'd6);
        // R3: width code 0 means 32 bits
        run_op("R3", 3'd7, 32'h1234_5678, 32'hCAFE_F00D, 32'd7, 5'd0);
        run_op("R3", 3'd2, 32'h0F0F_0F0F, '0, 32'd0, 5'd0);
        // R5: sign fill with top field bit set, and clear
        run_op("R5", 3'd3, 32'h0800_0000, '0, 32'd4, 5'd8);
        run_op("R5", 3'd3, 32'h7000_0000, '0, 32'd0, 5'd4);
        // R4: extract unsigned of a negative-looking field
        run_op("R4", 3'd1, 32'hF000_0000, '0, 32'd0, 5'd4);
        // R6: insert of zero value gives Z; insert with top bit set gives N
        run_op("R6", 3'd7, 32'hFFFF_FFFF, 32'hFFFF_FF00, 32'd12, 5'd8);
        run_op("R6", 3'd7, 32'h0000_0000, 32'h0000_0008, 32'd30, 5'd4);
        // R7: set and complement near the wrap point
        run_op("R7", 3'd6, 32'h0000_0000, '0, 32'd28, 5'd8);
        run_op("R7", 3'd2, 32'h8000_0001, '0, 32'd31, 5'd2);
        // R8: test leaves the register
        run_op("R8", 3'd0, 32'h0000_0000, '0, 32'd5, 5'd3);
        // R9: negative offset, empty field, top of range wrap
        run_op("R9", 3'd5, 32'h0000_0001, '0, 32'hFFFF_FFFD, 5'd0);
        run_op("R9", 3'd5, 32'h0000_0000, '0, 32'h7FFF_FFFF, 5'd4);
        run_op("R9", 3'd5, 32'h0000_0000, '0, 32'hFFFF_FFF0, 5'd0);
        run_op("R9", 3'd5, 32'h0001_0000, '0, 32'h0000_0043, 5'd20);

        // R1: outputs hold with no request
        held = new_reg;
        @(negedge clk);
        checks++;
        if (valid !== 1'b0) fail_line("R1", "valid idle", 32'(valid), 32'd0);
        checks++;
        if (new_reg !== held) fail_line("R1", "hold new_reg", new_reg, held);

        // R10: random mix over all opcodes, offsets and widths
        for (int t = 0; t < 600; t++) begin
            logic [2:0] op;
            op = 3'($urandom);
            run_op(op == 3'd5 ? "R9" : "R10", op, $urandom, $urandom, $urandom, 5'($urandom));
        end
        finish_run();
    end
endmodule